// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block collects the interrupt sources of a UART channel and presents the host with one interrupt line plus a four-bit identification code naming the single most urgent pending cause. Six causes are handled: a receive line error, receive data ready, receive character timeout, transmit holding register empty, a modem status change, and a flow-control (CTS/RTS) event. Line error and data ready arrive as levels that the surrounding logic holds until serviced. The other four arrive as one-cycle event pulses and are held in sticky pending bits inside the block until their clearing action occurs.

Each cause is gated by its own enable bit. A pending but disabled cause stays latched and shows up as soon as it is enabled. Among the enabled pending causes, a fixed priority chain picks the one to report. Receive data ready and receive timeout share one level: whichever is present is reported, and data ready is named when both are. Flow-control events rank below everything else, so they stay hidden until all other causes are cleared. The transmit-empty bit is set by reset, so a channel whose transmit enable is on raises an interrupt immediately after reset.

All ports are plain control and status pins; there is no data stream and therefore no valid/ready handshake. Read and write strobes are single-cycle pulses, and their clearing effect is visible from the cycle after the strobe.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset the transmit-empty pending bit is set and all other sticky bits are clear; with enable bit 1 set, `irq` is 1 and `iir_id` is 4'b0010.
- R2: `irq` is 1 exactly when at least one cause is both pending and enabled. Enable bits: 0 data ready, 1 transmit empty, 2 line error, 3 receive timeout, 4 modem status, 5 flow control.
- R3: Priority from high to low is line error (4'b0110), data ready / timeout, transmit empty (4'b0010), modem status (4'b0000), flow control (4'b1110). Only the highest enabled pending cause is reported.
- R4: Data ready (4'b0100) and receive timeout (4'b1100) share one priority level, and data ready is reported when both are present. The timeout is reported only while enable bit 3 is set.
- R5: A `iir_read` strobe clears the transmit-empty bit only when `iir_id` is 4'b0010 in that cycle. A read while another cause is reported leaves it pending.
- R6: A `thr_write` strobe clears the transmit-empty bit; a `thr_empty_evt` pulse sets it.
- R7: A flow-control event becomes visible only after every higher enabled cause is cleared, and an `iir_read` strobe while it is reported (4'b1110) clears it.
- R8: A `rx_read` strobe clears the timeout bit and a `msr_read` strobe clears the modem-status bit.
- R9: When a set pulse and a clearing strobe for the same sticky bit arrive in the same cycle, the bit ends up set.
- R10: With no enabled pending cause, `iir_id` is 4'b0001 and `irq` is 0.
- R11: Enable bits gate reporting only. A sticky bit stays pending while its cause is disabled and is reported once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 6 | Per-cause interrupt enables (bit map in R2) |
| lsr_err | input | 1 | Receive line error level |
| rx_ready | input | 1 | Receive data ready level (trigger level reached) |
| rx_timeout_evt | input | 1 | Receive timeout event pulse |
| rx_read | input | 1 | Receive holding register read strobe |
| thr_empty_evt | input | 1 | Transmit holding register became empty pulse |
| thr_write | input | 1 | Transmit holding register write strobe |
| modem_evt | input | 1 | Modem status change pulse |
| msr_read | input | 1 | Modem status register read strobe |
| flow_evt | input | 1 | CTS/RTS flow-control event pulse |
| iir_read | input | 1 | Identification register read strobe |
| irq | output | 1 | Interrupt request, active high |
| iir_id | output | 4 | Code of the highest-priority pending cause |

## Verification
The bench targets the masking corner cases. It stacks all six causes and then retires them one at a time. A design with a wrong priority order, or one that lets the flow-control event through early, reports the wrong code partway down the stack. It reads the identification register while the timeout is being reported, to catch a design that clears transmit-empty whether or not it was the reported cause. It also applies a set pulse and a clear strobe in the same cycle, and it toggles enables over latched causes. These catch a design that lets the clear win or gates the latch instead of the report. A long random phase compares every cycle against a behavioural model, so wrong codes and lost or stuck pending bits show up.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC  = 6;
  localparam int NUM_STKY = 4;
  localparam int EN_W     = 6;
  localparam int ID_W     = 4;
  localparam int IDX_W    = $clog2(NUM_SRC);

  // Report order: index 0 is the most urgent cause.
  typedef enum logic [IDX_W-1:0] {
    SRC_LINE    = 3'd0,
    SRC_RXDATA  = 3'd1,
    SRC_RXTO    = 3'd2,
    SRC_TXEMPTY = 3'd3,
    SRC_MODEM   = 3'd4,
    SRC_FLOW    = 3'd5
  } src_e;

  // Enable bit positions as seen by the host.
  localparam int EN_RXDATA  = 0;
  localparam int EN_TXEMPTY = 1;
  localparam int EN_LINE    = 2;
  localparam int EN_RXTO    = 3;
  localparam int EN_MODEM   = 4;
  localparam int EN_FLOW    = 5;

  // Positions inside the sticky pending bank.
  localparam int STK_RXTO    = 0;
  localparam int STK_TXEMPTY = 1;
  localparam int STK_MODEM   = 2;
  localparam int STK_FLOW    = 3;
  localparam logic [NUM_STKY-1:0] STK_RST = 4'b0010;

  localparam logic [ID_W-1:0] ID_NONE    = 4'b0001;
  localparam logic [ID_W-1:0] ID_LINE    = 4'b0110;
  localparam logic [ID_W-1:0] ID_RXDATA  = 4'b0100;
  localparam logic [ID_W-1:0] ID_RXTO    = 4'b1100;
  localparam logic [ID_W-1:0] ID_TXEMPTY = 4'b0010;
  localparam logic [ID_W-1:0] ID_MODEM   = 4'b0000;
  localparam logic [ID_W-1:0] ID_FLOW    = 4'b1110;

  function automatic logic [ID_W-1:0] code_of(input int idx);
    case (idx)
      SRC_LINE:    code_of = ID_LINE;
      SRC_RXDATA:  code_of = ID_RXDATA;
      SRC_RXTO:    code_of = ID_RXTO;
      SRC_TXEMPTY: code_of = ID_TXEMPTY;
      SRC_MODEM:   code_of = ID_MODEM;
      SRC_FLOW:    code_of = ID_FLOW;
      default:     code_of = ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_sticky_bank.sv
module uart_irq_sticky_bank #(
  parameter int            N       = 4,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_o[g] <= RST_VAL[g];
      else if (set_i[g])
        pend_o[g] <= 1'b1;          // a new event outranks a clear
      else if (clr_i[g])
        pend_o[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_irq_first_one.sv
module uart_irq_first_one #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);

  logic [N:0] blocked;

  always_comb begin
    blocked[0] = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt_o[i]     = req_i[i] & ~blocked[i];
      blocked[i+1] = blocked[i] | req_i[i];
    end
    any_o = blocked[N];
  end

endmodule

// File: rtl/uart_irq_code_mux.sv
module uart_irq_code_mux
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]    gnt_i,
  input  logic            any_i,
  output logic [ID_W-1:0] id_o
);

  logic [ID_W-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < N; i++)
      if (gnt_i[i]) merged = merged | code_of(i);
    id_o = any_i ? merged : ID_NONE;
  end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] ier,
  input  logic            lsr_err,
  input  logic            rx_ready,
  input  logic            rx_timeout_evt,
  input  logic            rx_read,
  input  logic            thr_empty_evt,
  input  logic            thr_write,
  input  logic            modem_evt,
  input  logic            msr_read,
  input  logic            flow_evt,
  input  logic            iir_read,
  output logic            irq,
  output logic [ID_W-1:0] iir_id
);

  logic [NUM_STKY-1:0] stk_set, stk_clr, stk_pend;
  logic [NUM_SRC-1:0]  pend, en, req, gnt;
  logic                any;

  // Clear strokes; the identification read only retires the cause it names.
  always_comb begin
    stk_set = '0;
    stk_clr = '0;
    stk_set[STK_RXTO]    = rx_timeout_evt;
    stk_set[STK_TXEMPTY] = thr_empty_evt;
    stk_set[STK_MODEM]   = modem_evt;
    stk_set[STK_FLOW]    = flow_evt;
    stk_clr[STK_RXTO]    = rx_read;
    stk_clr[STK_TXEMPTY] = thr_write | (iir_read & gnt[SRC_TXEMPTY]);
    stk_clr[STK_MODEM]   = msr_read;
    stk_clr[STK_FLOW]    = iir_read & gnt[SRC_FLOW];
  end

  uart_irq_sticky_bank #(
    .N       (NUM_STKY),
    .RST_VAL (STK_RST)
  ) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (stk_set),
    .clr_i  (stk_clr),
    .pend_o (stk_pend)
  );

  // Map causes and enables into report order.
  always_comb begin
    pend[SRC_LINE]    = lsr_err;
    pend[SRC_RXDATA]  = rx_ready;
    pend[SRC_RXTO]    = stk_pend[STK_RXTO];
    pend[SRC_TXEMPTY] = stk_pend[STK_TXEMPTY];
    pend[SRC_MODEM]   = stk_pend[STK_MODEM];
    pend[SRC_FLOW]    = stk_pend[STK_FLOW];

    en[SRC_LINE]      = ier[EN_LINE];
    en[SRC_RXDATA]    = ier[EN_RXDATA];
    en[SRC_RXTO]      = ier[EN_RXTO];
    en[SRC_TXEMPTY]   = ier[EN_TXEMPTY];
    en[SRC_MODEM]     = ier[EN_MODEM];
    en[SRC_FLOW]      = ier[EN_FLOW];
  end

  assign req = pend & en;
  assign irq = |req;

  uart_irq_first_one #(
    .N (NUM_SRC)
  ) u_pick (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (any)
  );

  uart_irq_code_mux #(
    .N (NUM_SRC)
  ) u_code (
    .gnt_i (gnt),
    .any_i (any),
    .id_o  (iir_id)
  );

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [EN_W-1:0] ier,
  input logic            lsr_err,
  input logic            rx_ready,
  input logic            thr_empty_evt,
  input logic            thr_write,
  input logic            modem_evt,
  input logic            msr_read,
  input logic            iir_read,
  input logic            irq,
  input logic [ID_W-1:0] iir_id
);

  // R2
  irq_id_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir_id != ID_NONE));

  // R3
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[EN_LINE] && lsr_err) |-> (iir_id == ID_LINE));

  // R4
  rxdata_over_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[EN_RXDATA] && rx_ready && !(ier[EN_LINE] && lsr_err)) |-> (iir_id == ID_RXDATA));

  // R5
  tx_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_read && iir_id == ID_TXEMPTY && !thr_empty_evt) |=> (iir_id != ID_TXEMPTY));

  // R6
  tx_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_write && !thr_empty_evt) |=> (iir_id != ID_TXEMPTY));

  // R8
  modem_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_read && !modem_evt) |=> (iir_id != ID_MODEM));

  // R10
  none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == '0) |-> (!irq && iir_id == ID_NONE));

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ier           (ier),
  .lsr_err       (lsr_err),
  .rx_ready      (rx_ready),
  .thr_empty_evt (thr_empty_evt),
  .thr_write     (thr_write),
  .modem_evt     (modem_evt),
  .msr_read      (msr_read),
  .iir_read      (iir_read),
  .irq           (irq),
  .iir_id        (iir_id)
);

// File: tb/tb_uart_irq_arbiter.sv
module tb_uart_irq_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ier = 6'b000010;
  logic lsr_err = 0, rx_ready = 0, rx_timeout_evt = 0, rx_read = 0;
  logic thr_empty_evt = 0, thr_write = 0, modem_evt = 0, msr_read = 0;
  logic flow_evt = 0, iir_read = 0;
  logic       irq;
  logic [3:0] iir_id;

  int unsigned checks = 0;
  int unsigned failures = 0;
  bit          done = 0;

  always #2 clk = ~clk;   // 250 MHz

  uart_irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_err(lsr_err), .rx_ready(rx_ready),
    .rx_timeout_evt(rx_timeout_evt), .rx_read(rx_read), .thr_empty_evt(thr_empty_evt),
    .thr_write(thr_write), .modem_evt(modem_evt), .msr_read(msr_read),
    .flow_evt(flow_evt), .iir_read(iir_read), .irq(irq), .iir_id(iir_id)
  );

  // Behavioural reference: four sticky flags and a priority if-chain.
  bit m_to = 0, m_tx = 1, m_ms = 0, m_fl = 0;

  function automatic logic [3:0] model_id();
    if (ier[2] && lsr_err)      return 4'b0110;
    else if (ier[0] && rx_ready) return 4'b0100;
    else if (ier[3] && m_to)     return 4'b1100;
    else if (ier[1] && m_tx)     return 4'b0010;
    else if (ier[4] && m_ms)     return 4'b0000;
    else if (ier[5] && m_fl)     return 4'b1110;
    else                         return 4'b0001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [3:0] cur;
    if (!rst_n) begin
      m_to <= 0; m_tx <= 1; m_ms <= 0; m_fl <= 0;
    end else begin
      cur = model_id();
      if (rx_timeout_evt) m_to <= 1; else if (rx_read) m_to <= 0;
      if (thr_empty_evt) m_tx <= 1;
      else if (thr_write || (iir_read && cur == 4'b0010)) m_tx <= 0;
      if (modem_evt) m_ms <= 1; else if (msr_read) m_ms <= 0;
      if (flow_evt) m_fl <= 1; else if (iir_read && cur == 4'b1110) m_fl <= 0;
    end
  end

  function automatic string tag_of(input logic [3:0] id);
    case (id)
      4'b0001: return "R10";
      4'b0110: return "R3";
      4'b0100, 4'b1100: return "R4";
      4'b0010: return "R5";
      4'b0000: return "R8";
      default: return "R7";
    endcase
  endfunction

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    logic [3:0] e;
    if (rst_n && !done) begin
      e = model_id();
      checks++;
      if (iir_id !== e || irq !== (e != 4'b0001)) begin
        failures++;
        $display("FAIL %s model: id=%b irq=%b expected id=%b irq=%b",
                 tag_of(e), iir_id, irq, e, (e != 4'b0001));
      end
    end
  end

  task automatic chk(input string tag, input logic [3:0] eid, input logic eirq);
    checks++;
    if (iir_id !== eid || irq !== eirq) begin
      failures++;
      $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b", tag, iir_id, irq, eid, eirq);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1", 4'b0010, 1'b1);

    ier = 6'b000000; step(); chk("R10", 4'b0001, 1'b0);
    ier = 6'b000010; step(); chk("R11", 4'b0010, 1'b1);

    iir_read = 1; step(); iir_read = 0; chk("R5", 4'b0001, 1'b0);
    thr_empty_evt = 1; step(); thr_empty_evt = 0; chk("R6", 4'b0010, 1'b1);
    thr_write = 1; step(); thr_write = 0; chk("R6", 4'b0001, 1'b0);
    thr_write = 1; thr_empty_evt = 1; step(); thr_write = 0; thr_empty_evt = 0;
    chk("R9", 4'b0010, 1'b1);

    // Stack every cause, then retire them in turn.
    ier = 6'b111111; lsr_err = 1; rx_ready = 1;
    rx_timeout_evt = 1; modem_evt = 1; flow_evt = 1;
    step(); rx_timeout_evt = 0; modem_evt = 0; flow_evt = 0;
    chk("R3", 4'b0110, 1'b1);
    lsr_err = 0; step(); chk("R4", 4'b0100, 1'b1);
    rx_ready = 0; step(); chk("R4", 4'b1100, 1'b1);
    iir_read = 1; step(); iir_read = 0; chk("R5", 4'b1100, 1'b1);
    rx_read = 1; step(); rx_read = 0; chk("R8", 4'b0010, 1'b1);
    iir_read = 1; step(); iir_read = 0; chk("R3", 4'b0000, 1'b1);
    msr_read = 1; step(); msr_read = 0; chk("R7", 4'b1110, 1'b1);
    iir_read = 1; step(); iir_read = 0; chk("R7", 4'b0001, 1'b0);

    // Timeout gated by enable bit 3.
    ier = 6'b110111; rx_timeout_evt = 1; step(); rx_timeout_evt = 0;
    chk("R4", 4'b0001, 1'b0);
    ier = 6'b111111; step(); chk("R11", 4'b1100, 1'b1);
    rx_read = 1; step(); rx_read = 0; chk("R8", 4'b0001, 1'b0);

    ier = 6'b000001; rx_ready = 1; step(); chk("R2", 4'b0100, 1'b1);
    ier = 6'b000000; step(); chk("R2", 4'b0001, 1'b0);
    rx_ready = 0;

    // Random phase, compared every cycle by the model.
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) ier = 6'($urandom);
      lsr_err        = ($urandom_range(0, 7) == 0);
      rx_ready       = ($urandom_range(0, 3) == 0);
      rx_timeout_evt = ($urandom_range(0, 7) == 0);
      rx_read        = ($urandom_range(0, 5) == 0);
      thr_empty_evt  = ($urandom_range(0, 7) == 0);
      thr_write      = ($urandom_range(0, 7) == 0);
      modem_evt      = ($urandom_range(0, 7) == 0);
      msr_read       = ($urandom_range(0, 7) == 0);
      flow_evt       = ($urandom_range(0, 7) == 0);
      iir_read       = ($urandom_range(0, 2) == 0);
      step();
    end
    finish_run();
  end

endmodule